// File: doc/BRIEF.md
# NAND Reed-Solomon ECC Register Front End

This block is the software-visible face of a Reed-Solomon error-correction engine for NAND flash. A 32-bit register bus reaches the control word, the nine parity bytes, the status word with its interrupt enables, and a bank of per-error report words. The block runs exactly one job at a time on the engine behind it: an encode, which computes parity, or a decode, which checks a codeword against parity loaded beforehand. The engine side uses a start/done handshake. On a finished encode the engine returns parity; on a finished decode it returns error flags, an error count and the reports.

For an encode, software sets enable with the encode bit, streams the page through the data register and waits for the encode-finished flag. For a decode, it sets enable with the encode bit clear, fills the parity bytes, and then sets parity-ready. Only that last write launches the engine. Software then reads the error count from the top bits of status and walks that many report words. A single level interrupt output combines the status flags with a per-flag enable register.

Top module: `rs_ecc_csr`

## Requirements
- R1: After reset, every readable register reads zero, and `irq`, `eng_start` and `eng_data_valid` are low.
- R2: Control word (offset 0x00): bit0 enable, bit1 soft reset, bit2 mode select, bit3 encode (1) / decode (0), bit4 parity-ready. Bit1 reads 1 only in the cycle that follows its write and 0 after that. The other bits read back as written.
- R3: With enable=1 and encode=1, `eng_start` pulses high for exactly one cycle. The pulse comes in the first cycle after the control write, or after the soft-reset cycle if one is pending, and `eng_encode` is high.
- R4: With enable=1 and encode=0, no start happens until parity-ready is 1. The start then follows the parity-ready write by one cycle, with `eng_encode` low and `eng_par_out` carrying the loaded parity bytes.
- R5: An `eng_done` pulse during an encode job loads `eng_par_in` into the parity registers and sets status bit2, visible the cycle after the pulse. Parity byte i sits in the word at 0x08 + 4·(i/4), lane i%4 (bits 8·(i%4) and up).
- R6: An `eng_done` pulse during a decode job sets status bit3, copies `eng_err_flag` to bit0 and `eng_uncor_flag` to bit1, and writes min(`eng_err_cnt`, ERR_SLOTS) to bits 31:29. Report n (0x1C + 4n) holds position in bits 24:16 and mask in bits 8:0 when n is below that count, and 0 otherwise.
- R7: Parity words accept byte-enabled writes and change only the enabled lanes. Lanes beyond byte 8 read 0.
- R8: Writing 0 to the status word (0x14) clears every status flag and the count. A nonzero write leaves status unchanged.
- R9: Soft reset clears the parity bytes, the error reports, parity-ready and the job state, leaves status untouched, and re-arms the block for a new job.
- R10: Clearing enable during a job aborts it. A later `eng_done` changes neither status nor parity, and no new start follows.
- R11: `irq` is high exactly when some status flag in bits 4:0 is set and its enable bit at 0x18 is set. Status bit4 is set by `eng_pad_done` while enabled.
- R12: A bus write to the data register (0x04) while enabled presents byte lane 0 on `eng_data_byte`, with `eng_data_valid` high in that same cycle. While disabled, a write to it gives no valid.
- R13: After a job finishes, no further start occurs until a soft reset or an enable toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_start | output | 1 | One-cycle job start pulse |
| eng_encode | output | 1 | Job direction, 1 = encode |
| eng_rs_sel | output | 1 | Mode select bit passed to the engine |
| eng_par_out | output | PAR_BYTES*8 | Parity bytes for decode, byte 0 in the low bits |
| eng_data_valid | output | 1 | Data byte strobe |
| eng_data_byte | output | 8 | Streamed data byte |
| eng_done | input | 1 | Job finished pulse |
| eng_par_in | input | PAR_BYTES*8 | Parity computed by an encode |
| eng_err_flag | input | 1 | Decode found errors |
| eng_uncor_flag | input | 1 | Decode found uncorrectable errors |
| eng_err_cnt | input | 3 | Number of error reports |
| eng_err_pos | input | ERR_SLOTS*POS_W | Error positions, slot 0 low |
| eng_err_mask | input | ERR_SLOTS*MASK_W | Error masks, slot 0 low |
| eng_pad_done | input | 1 | Padding finished pulse |
| irq | output | 1 | Level interrupt |

## Verification
Register reads are combinational, so a read can be checked in any cycle. Each write or engine pulse is driven on the falling edge, and its effect is sampled on the next falling edge, one register stage later. A start pulse is due on the falling edge right after the launching write. When soft reset is set, the start comes one falling edge later. A data-port strobe is due within the write cycle itself, so the bench samples it shortly after driving the write. A pulse counter on the falling edge confirms that aborted, finished and not-yet-ready jobs produce no extra starts.

// File: rtl/rs_ecc_csr_pkg.sv
package rs_ecc_csr_pkg;

   // byte offsets of the register words
   localparam int unsigned OFS_CTRL = 32'h00;
   localparam int unsigned OFS_DATA = 32'h04;
   localparam int unsigned OFS_PAR0 = 32'h08;
   localparam int unsigned OFS_STAT = 32'h14;
   localparam int unsigned OFS_IEN  = 32'h18;
   localparam int unsigned OFS_ERR0 = 32'h1C;

   // control bits
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_SRST = 1;
   localparam int unsigned CB_MODE = 2;
   localparam int unsigned CB_ENC  = 3;
   localparam int unsigned CB_PRDY = 4;

   // status bits
   localparam int unsigned SB_ERR   = 0;
   localparam int unsigned SB_UNCOR = 1;
   localparam int unsigned SB_EFIN  = 2;
   localparam int unsigned SB_DFIN  = 3;
   localparam int unsigned SB_PAD   = 4;
   localparam int unsigned SB_NFLAG = 5;
   localparam int unsigned SB_CNT   = 29;

   typedef enum logic [1:0] {
      JOB_IDLE = 2'd0,
      JOB_BUSY = 2'd1,
      JOB_FIN  = 2'd2
   } job_state_e;

endpackage

// File: rtl/rs_ecc_job_fsm.sv
module rs_ecc_job_fsm
   import rs_ecc_csr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic enc,
   input  logic prdy,
   input  logic soft_rst,
   input  logic done,
   output logic start,
   output logic capture,
   output logic busy,
   output logic fin
);

   job_state_e state_q, state_d;
   logic       go;

   assign go      = en & (enc | prdy) & ~soft_rst;
   assign start   = (state_q == JOB_IDLE) & go;
   assign capture = (state_q == JOB_BUSY) & en & done & ~soft_rst;
   assign busy    = (state_q == JOB_BUSY);
   assign fin     = (state_q == JOB_FIN);

   always_comb begin
      state_d = state_q;
      if (soft_rst) begin
         state_d = JOB_IDLE;
      end else begin
         unique case (state_q)
            JOB_IDLE: if (go)        state_d = JOB_BUSY;
            JOB_BUSY: if (!en)       state_d = JOB_IDLE;
                      else if (done) state_d = JOB_FIN;
            JOB_FIN:  if (!en)       state_d = JOB_IDLE;
            default:                 state_d = JOB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= JOB_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/rs_ecc_parity_bank.sv
module rs_ecc_parity_bank #(
   parameter int unsigned NBYTES = 9,
   localparam int unsigned NWORDS = (NBYTES + 3) / 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  load,
   input  logic [NBYTES*8-1:0]   load_bytes,
   input  logic [NWORDS-1:0]     wr_word,
   input  logic [3:0]            be,
   input  logic [31:0]           wdata,
   output logic [NBYTES*8-1:0]   par_flat,
   output logic [NWORDS*32-1:0]  rd_words
);

   logic [7:0] par_q [NBYTES];

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      localparam int unsigned W = b / 4;
      localparam int unsigned L = b % 4;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    par_q[b] <= '0;
         else if (clr)                  par_q[b] <= '0;
         else if (load)                 par_q[b] <= load_bytes[b*8 +: 8];
         else if (wr_word[W] && be[L])  par_q[b] <= wdata[L*8 +: 8];
      end
      assign par_flat[b*8 +: 8] = par_q[b];
   end

   for (genvar s = 0; s < NWORDS * 4; s++) begin : g_lane
      if (s < NBYTES) begin : g_used
         assign rd_words[s*8 +: 8] = par_q[s];
      end else begin : g_pad
         assign rd_words[s*8 +: 8] = 8'h00;
      end
   end

endmodule

// File: rtl/rs_ecc_err_bank.sv
module rs_ecc_err_bank #(
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned POS_W  = 9,
   parameter int unsigned MASK_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    capture,
   input  logic [2:0]              valid_cnt,
   input  logic [SLOTS*POS_W-1:0]  pos_in,
   input  logic [SLOTS*MASK_W-1:0] mask_in,
   output logic [SLOTS*32-1:0]     rd_words
);

   logic [POS_W-1:0]  pos_q  [SLOTS];
   logic [MASK_W-1:0] mask_q [SLOTS];

   for (genvar n = 0; n < SLOTS; n++) begin : g_slot
      logic keep;
      assign keep = (32'(valid_cnt) > n);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pos_q[n]  <= '0;
            mask_q[n] <= '0;
         end else if (clr) begin
            pos_q[n]  <= '0;
            mask_q[n] <= '0;
         end else if (capture) begin
            pos_q[n]  <= keep ? pos_in[n*POS_W +: POS_W]    : '0;
            mask_q[n] <= keep ? mask_in[n*MASK_W +: MASK_W] : '0;
         end
      end
      always_comb begin
         rd_words[n*32 +: 32]                = '0;
         rd_words[n*32 + 16 +: POS_W]        = pos_q[n];
         rd_words[n*32 +: MASK_W]            = mask_q[n];
      end
   end

endmodule

// File: rtl/rs_ecc_csr.sv
module rs_ecc_csr
   import rs_ecc_csr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PAR_BYTES = 9,
   parameter int unsigned ERR_SLOTS = 4,
   parameter int unsigned POS_W     = 9,
   parameter int unsigned MASK_W    = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [3:0]                  bus_be,
   input  logic [31:0]                 bus_wdata,
   output logic [31:0]                 bus_rdata,
   output logic                        eng_start,
   output logic                        eng_encode,
   output logic                        eng_rs_sel,
   output logic [PAR_BYTES*8-1:0]      eng_par_out,
   output logic                        eng_data_valid,
   output logic [7:0]                  eng_data_byte,
   input  logic                        eng_done,
   input  logic [PAR_BYTES*8-1:0]      eng_par_in,
   input  logic                        eng_err_flag,
   input  logic                        eng_uncor_flag,
   input  logic [2:0]                  eng_err_cnt,
   input  logic [ERR_SLOTS*POS_W-1:0]  eng_err_pos,
   input  logic [ERR_SLOTS*MASK_W-1:0] eng_err_mask,
   input  logic                        eng_pad_done,
   output logic                        irq
);

   localparam int unsigned WA     = ADDR_W - 2;
   localparam int unsigned NPW    = (PAR_BYTES + 3) / 4;
   localparam logic [WA-1:0] I_CTRL = WA'(OFS_CTRL >> 2);
   localparam logic [WA-1:0] I_DATA = WA'(OFS_DATA >> 2);
   localparam logic [WA-1:0] I_STAT = WA'(OFS_STAT >> 2);
   localparam logic [WA-1:0] I_IEN  = WA'(OFS_IEN >> 2);
   localparam int unsigned   I_PAR0 = OFS_PAR0 >> 2;
   localparam int unsigned   I_ERR0 = OFS_ERR0 >> 2;
   localparam logic [2:0]    CNT_MAX = 3'(ERR_SLOTS);

   initial begin
      assert (ADDR_W >= 6 && ADDR_W <= 16)
         else $error("rs_ecc_csr: ADDR_W out of range");
      assert (PAR_BYTES >= 1 && NPW <= (OFS_STAT - OFS_PAR0) / 4)
         else $error("rs_ecc_csr: parity words overlap status");
      assert (ERR_SLOTS >= 1 && ERR_SLOTS <= 7)
         else $error("rs_ecc_csr: ERR_SLOTS must be 1..7");
      assert (POS_W <= 13 && MASK_W <= 16)
         else $error("rs_ecc_csr: report field too wide");
      assert (OFS_ERR0 + 4 * ERR_SLOTS <= (1 << ADDR_W))
         else $error("rs_ecc_csr: reports exceed address space");
   end

   // ---------------- bus decode ----------------
   logic [WA-1:0]  widx;
   logic           wr_hit;
   logic           wr_ctrl, wr_stat, wr_ien, wr_data;
   logic [NPW-1:0] wr_par;

   assign widx    = bus_addr[ADDR_W-1:2];
   assign wr_hit  = bus_sel & bus_wr;
   assign wr_ctrl = wr_hit & (widx == I_CTRL) & bus_be[0];
   assign wr_stat = wr_hit & (widx == I_STAT) & (bus_wdata == 32'h0);
   assign wr_ien  = wr_hit & (widx == I_IEN) & bus_be[0];
   assign wr_data = wr_hit & (widx == I_DATA) & bus_be[0];

   for (genvar k = 0; k < NPW; k++) begin : g_parsel
      assign wr_par[k] = wr_hit & (widx == WA'(I_PAR0 + k));
   end

   // ---------------- control word ----------------
   logic ctrl_en, ctrl_rst, ctrl_mode, ctrl_enc, ctrl_prdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en   <= 1'b0;
         ctrl_rst  <= 1'b0;
         ctrl_mode <= 1'b0;
         ctrl_enc  <= 1'b0;
         ctrl_prdy <= 1'b0;
      end else if (wr_ctrl) begin
         ctrl_en   <= bus_wdata[CB_EN];
         ctrl_rst  <= bus_wdata[CB_SRST];
         ctrl_mode <= bus_wdata[CB_MODE];
         ctrl_enc  <= bus_wdata[CB_ENC];
         ctrl_prdy <= bus_wdata[CB_PRDY];
      end else begin
         ctrl_rst  <= 1'b0;
         if (ctrl_rst) ctrl_prdy <= 1'b0;
      end
   end

   // ---------------- job sequencing ----------------
   logic job_capture, job_busy, job_fin;
   logic cap_enc, cap_dec;

   rs_ecc_job_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_en),
      .enc      (ctrl_enc),
      .prdy     (ctrl_prdy),
      .soft_rst (ctrl_rst),
      .done     (eng_done),
      .start    (eng_start),
      .capture  (job_capture),
      .busy     (job_busy),
      .fin      (job_fin)
   );

   assign cap_enc = job_capture &  ctrl_enc;
   assign cap_dec = job_capture & ~ctrl_enc;

   // ---------------- parity and report banks ----------------
   logic [NPW*32-1:0]       par_rd;
   logic [ERR_SLOTS*32-1:0] err_rd;
   logic [2:0]              cnt_sat;

   assign cnt_sat = (eng_err_cnt > CNT_MAX) ? CNT_MAX : eng_err_cnt;

   rs_ecc_parity_bank #(.NBYTES(PAR_BYTES)) u_par (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (ctrl_rst),
      .load       (cap_enc),
      .load_bytes (eng_par_in),
      .wr_word    (wr_par),
      .be         (bus_be),
      .wdata      (bus_wdata),
      .par_flat   (eng_par_out),
      .rd_words   (par_rd)
   );

   rs_ecc_err_bank #(
      .SLOTS  (ERR_SLOTS),
      .POS_W  (POS_W),
      .MASK_W (MASK_W)
   ) u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ctrl_rst),
      .capture   (cap_dec),
      .valid_cnt (cnt_sat),
      .pos_in    (eng_err_pos),
      .mask_in   (eng_err_mask),
      .rd_words  (err_rd)
   );

   // ---------------- status and interrupt ----------------
   logic [SB_NFLAG-1:0] stat_flags, ien_q;
   logic [2:0]          stat_cnt;
   logic [31:0]         stat_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_flags <= '0;
         stat_cnt   <= '0;
      end else begin
         if (wr_stat) begin
            stat_flags <= '0;
            stat_cnt   <= '0;
         end
         if (cap_enc) stat_flags[SB_EFIN] <= 1'b1;
         if (cap_dec) begin
            stat_flags[SB_DFIN]  <= 1'b1;
            stat_flags[SB_ERR]   <= eng_err_flag;
            stat_flags[SB_UNCOR] <= eng_uncor_flag;
            stat_cnt             <= cnt_sat;
         end
         if (eng_pad_done && ctrl_en) stat_flags[SB_PAD] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= '0;
      else if (wr_ien) ien_q <= bus_wdata[SB_NFLAG-1:0];
   end

   assign stat_word = {stat_cnt, {(SB_CNT - SB_NFLAG){1'b0}}, stat_flags};
   assign irq       = |(stat_flags & ien_q);

   // ---------------- engine side ----------------
   assign eng_encode     = ctrl_enc;
   assign eng_rs_sel     = ctrl_mode;
   assign eng_data_valid = wr_data & ctrl_en;
   assign eng_data_byte  = bus_wdata[7:0];

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (widx == I_CTRL) begin
         bus_rdata[CB_EN]   = ctrl_en;
         bus_rdata[CB_SRST] = ctrl_rst;
         bus_rdata[CB_MODE] = ctrl_mode;
         bus_rdata[CB_ENC]  = ctrl_enc;
         bus_rdata[CB_PRDY] = ctrl_prdy;
      end else if (widx == I_STAT) begin
         bus_rdata = stat_word;
      end else if (widx == I_IEN) begin
         bus_rdata[SB_NFLAG-1:0] = ien_q;
      end
      for (int k = 0; k < NPW; k++) begin
         if (widx == WA'(I_PAR0 + k)) bus_rdata = par_rd[k*32 +: 32];
      end
      for (int n = 0; n < ERR_SLOTS; n++) begin
         if (widx == WA'(I_ERR0 + n)) bus_rdata = err_rd[n*32 +: 32];
      end
   end

endmodule

// File: rtl/rs_ecc_csr_chk.sv
module rs_ecc_csr_chk #(
   parameter int unsigned PAR_BYTES = 9,
   parameter int unsigned ERR_SLOTS = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   eng_start,
   input logic                   eng_encode,
   input logic                   eng_done,
   input logic                   irq,
   input logic                   ctrl_en,
   input logic                   ctrl_rst,
   input logic                   ctrl_prdy,
   input logic                   job_busy,
   input logic                   job_fin,
   input logic [31:0]            stat_word,
   input logic [PAR_BYTES*8-1:0] par_flat
);

   // R3: a start lasts one cycle
   a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   // R4: decode start only with parity-ready
   a_r4_decode_needs_prdy: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && !eng_encode) |-> ctrl_prdy);

   // R5: accepted encode completion raises encode-finished
   a_r5_enc_finish: assert property (@(posedge clk) disable iff (!rst_n)
      (job_busy && ctrl_en && !ctrl_rst && eng_done && eng_encode) |=> (stat_word[2] && job_fin));

   // R6: report count never exceeds the bank
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[31:29] <= 3'(ERR_SLOTS));

   // R9: soft reset empties the parity bytes
   a_r9_par_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rst |=> (par_flat == '0));

   // R10: clearing enable leaves the busy state
   a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (job_busy && !ctrl_en) |=> !job_busy);

   // R11: interrupt only with a pending flag
   a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_word[4:0] != 5'd0));

   // R13: no start from the finished state
   a_r13_one_job: assert property (@(posedge clk) disable iff (!rst_n)
      job_fin |-> !eng_start);

endmodule

bind rs_ecc_csr rs_ecc_csr_chk #(
   .PAR_BYTES (PAR_BYTES),
   .ERR_SLOTS (ERR_SLOTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .eng_start (eng_start),
   .eng_encode(eng_encode),
   .eng_done  (eng_done),
   .irq       (irq),
   .ctrl_en   (ctrl_en),
   .ctrl_rst  (ctrl_rst),
   .ctrl_prdy (ctrl_prdy),
   .job_busy  (job_busy),
   .job_fin   (job_fin),
   .stat_word (stat_word),
   .par_flat  (eng_par_out)
);

// File: tb/test_rs_ecc_csr.sv
module test_rs_ecc_csr;

   localparam int NB = 9;
   localparam int NS = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [3:0]        bus_be = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              eng_start, eng_encode, eng_rs_sel, eng_data_valid;
   logic [NB*8-1:0]   eng_par_out;
   logic [7:0]        eng_data_byte;
   logic              eng_done = 1'b0;
   logic [NB*8-1:0]   eng_par_in = '0;
   logic              eng_err_flag = 1'b0, eng_uncor_flag = 1'b0;
   logic [2:0]        eng_err_cnt = '0;
   logic [NS*9-1:0]   eng_err_pos = '0, eng_err_mask = '0;
   logic              eng_pad_done = 1'b0;
   logic              irq;

   int                n_chk = 0, n_fail = 0, n_start = 0;
   logic              dv_seen;
   logic [7:0]        db_seen;
   logic [7:0]        par_m [12];

   always #10 clk = ~clk;

   rs_ecc_csr i_rs_ecc_csr (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_encode(eng_encode),
      .eng_rs_sel(eng_rs_sel), .eng_par_out(eng_par_out),
      .eng_data_valid(eng_data_valid), .eng_data_byte(eng_data_byte),
      .eng_done(eng_done), .eng_par_in(eng_par_in),
      .eng_err_flag(eng_err_flag), .eng_uncor_flag(eng_uncor_flag),
      .eng_err_cnt(eng_err_cnt), .eng_err_pos(eng_err_pos),
      .eng_err_mask(eng_err_mask), .eng_pad_done(eng_pad_done), .irq(irq));

   always @(negedge clk) if (rst_n && eng_start) n_start++;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      #1;
      dv_seen = eng_data_valid;
      db_seen = eng_data_byte;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   function automatic logic [31:0] exp_par_word(int k);
      logic [31:0] w = '0;
      for (int l = 0; l < 4; l++) w[l*8 +: 8] = par_m[4*k + l];
      return w;
   endfunction

   function automatic logic [31:0] exp_stat_dec(logic e, logic u, logic [2:0] c);
      logic [2:0] s = (c > 3'(NS)) ? 3'(NS) : c;
      return {s, 24'h0, 5'b01000 | {3'b000, u, e}};
   endfunction

   function automatic logic [31:0] exp_report(int n, logic [2:0] c);
      logic [2:0] s = (c > 3'(NS)) ? 3'(NS) : c;
      if (n >= int'(s)) return 32'h0;
      return {7'h0, eng_err_pos[n*9 +: 9], 7'h0, eng_err_mask[n*9 +: 9]};
   endfunction

   task automatic load_model_from(logic [NB*8-1:0] p);
      for (int b = 0; b < 12; b++) par_m[b] = (b < NB) ? p[b*8 +: 8] : 8'h00;
   endtask

   task automatic check_parity(string tag);
      logic [31:0] v;
      for (int k = 0; k < 3; k++) begin
         rd(8'h08 + 8'(4*k), v);
         chk(tag, v, exp_par_word(k));
      end
   endtask

   task automatic check_reports(string tag, logic [2:0] c);
      logic [31:0] v;
      for (int n = 0; n < NS; n++) begin
         rd(8'h1C + 8'(4*n), v);
         chk(tag, v, exp_report(n, c));
      end
   endtask

   task automatic rand_engine();
      logic [95:0] r;
      r = {$urandom(), $urandom(), $urandom()};
      eng_par_in   = r[NB*8-1:0];
      r = {$urandom(), $urandom(), $urandom()};
      eng_err_pos  = r[NS*9-1:0];
      r = {$urandom(), $urandom(), $urandom()};
      eng_err_mask = r[NS*9-1:0];
      eng_err_cnt  = 3'($urandom_range(0, 7));
      eng_err_flag = $urandom_range(0, 1) == 1;
      eng_uncor_flag = $urandom_range(0, 1) == 1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      int s0;
      void'($urandom(32'd1234));
      load_model_from('0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      foreach (par_m[i]) ;
      rd(8'h00, v); chk("R1 ctrl", v, 0);
      rd(8'h14, v); chk("R1 status", v, 0);
      rd(8'h18, v); chk("R1 irq enables", v, 0);
      check_parity("R1 parity");
      check_reports("R1 reports", 3'd0);
      chk("R1 irq/start", {30'h0, irq, eng_start}, 0);

      // R3/R2 encode with soft reset
      wr(8'h00, 32'h0F);
      rd(8'h00, v); chk("R2 reset bit visible", v, 32'h0F);
      chk("R3 no start in reset cycle", {31'h0, eng_start}, 0);
      @(negedge clk);
      chk("R3 start after reset cycle", {30'h0, eng_start, eng_encode}, 32'h3);
      rd(8'h00, v); chk("R2 reset bit self-clears", v, 32'h0D);
      s0 = n_start;
      rand_engine();
      done_pulse();
      load_model_from(eng_par_in);
      rd(8'h14, v); chk("R5 encode finished", v, 32'h4);
      check_parity("R5 parity loaded");
      repeat (3) @(negedge clk);
      chk("R13 no restart after finish", n_start, s0);

      // R8 status clear
      wr(8'h14, 32'h1F);
      rd(8'h14, v); chk("R8 nonzero write ignored", v, 32'h4);
      wr(8'h14, 32'h0);
      rd(8'h14, v); chk("R8 zero write clears", v, 0);

      // R9 soft reset clears parity and rearms, R10 abort
      wr(8'h00, 32'h0F);
      load_model_from('0);
      @(negedge clk);
      chk("R9 rearmed start", {31'h0, eng_start}, 1);
      check_parity("R9 parity cleared");
      s0 = n_start;
      wr(8'h00, 32'h0C);
      rand_engine();
      done_pulse();
      rd(8'h14, v); chk("R10 status untouched after abort", v, 0);
      check_parity("R10 parity untouched after abort");
      repeat (2) @(negedge clk);
      chk("R10 no start after abort", n_start, s0);

      // R12 data port
      wr(8'h04, 32'h1234_56A5);
      chk("R12 no strobe while disabled", {31'h0, dv_seen}, 0);
      wr(8'h00, 32'h05);
      wr(8'h04, 32'h0000_003C);
      chk("R12 strobe and byte", {23'h0, dv_seen, db_seen}, {23'h0, 1'b1, 8'h3C});

      // R4 decode waits for parity-ready, R7 byte writes
      wr(8'h00, 32'h07);
      s0 = n_start;
      repeat (3) @(negedge clk);
      chk("R4 no start before parity-ready", n_start, s0);
      wr(8'h10, 32'hFFFF_FFFF);
      par_m[8] = 8'hFF;
      rd(8'h10, v); chk("R7 lanes past byte 8 read zero", v, 32'h0000_00FF);
      for (int k = 0; k < 3; k++) begin
         logic [31:0] d = $urandom();
         logic [3:0]  be = 4'($urandom_range(1, 15));
         wr(8'h08 + 8'(4*k), d, be);
         for (int l = 0; l < 4; l++)
            if (be[l] && (4*k + l) < NB) par_m[4*k + l] = d[l*8 +: 8];
      end
      check_parity("R7 byte-enabled writes");
      wr(8'h00, 32'h15);
      chk("R4 start on parity-ready", {30'h0, eng_start, eng_encode}, 32'h2);
      for (int b = 0; b < NB; b++)
         chk("R4 parity presented", 32'(eng_par_out[b*8 +: 8]), 32'(par_m[b]));
      rand_engine();
      eng_err_cnt = 3'd6; eng_err_flag = 1'b1; eng_uncor_flag = 1'b0;
      done_pulse();
      rd(8'h14, v); chk("R6 decode status saturated", v, exp_stat_dec(1'b1, 1'b0, 3'd6));
      check_reports("R6 reports", 3'd6);

      // R11 interrupt
      wr(8'h18, 32'h08);
      chk("R11 irq on decode finish", {31'h0, irq}, 1);
      wr(8'h18, 32'h04);
      chk("R11 irq masked", {31'h0, irq}, 0);
      wr(8'h18, 32'h10);
      @(negedge clk); eng_pad_done = 1'b1;
      @(negedge clk); eng_pad_done = 1'b0;
      rd(8'h14, v); chk("R11 pad flag", 32'(v[4]), 1);
      chk("R11 irq on pad", {31'h0, irq}, 1);
      wr(8'h14, 32'h0);
      chk("R11 irq after clear", {31'h0, irq}, 0);

      // random jobs
      for (int it = 0; it < 24; it++) begin
         wr(8'h14, 32'h0);
         rand_engine();
         if ($urandom_range(0, 1) == 1) begin
            wr(8'h00, 32'h0F);
            @(negedge clk);
            chk("R3 random encode start", {31'h0, eng_start}, 1);
            done_pulse();
            load_model_from(eng_par_in);
            rd(8'h14, v); chk("R5 random encode status", v, 32'h4);
            check_parity("R5 random parity");
         end else begin
            wr(8'h00, 32'h07);
            load_model_from('0);
            wr(8'h00, 32'h15);
            chk("R4 random decode start", {30'h0, eng_start, eng_encode}, 32'h2);
            done_pulse();
            rd(8'h14, v);
            chk("R6 random decode status", v,
                exp_stat_dec(eng_err_flag, eng_uncor_flag, eng_err_cnt));
            check_reports("R6 random reports", eng_err_cnt);
            check_parity("R6 parity kept on decode");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule